// File: doc/BRIEF.md
# Group-Order Barrett Reducer

This block reduces a 512-bit unsigned value modulo the prime group order L = 2^252 + 27742317777372353535851937790883648493 of the twisted Edwards signature curve. The prime order is what hash outputs and scalar sums must be folded into. A caller presents the operand together with a one-cycle start pulse. The block then works through a Barrett estimate built around the scaled modulus 8L. It returns a 253-bit remainder, flagged by a one-cycle done pulse.

The quotient is estimated with the constant T = floor(2^512 / (8L)). Two products are formed on one shared bit-serial multiplier. The first is the upper 257 bits of the operand (bits 511..255) times T. The second is the top part of that product (bits above 256) times 8L. Only the low 257 bits of the operand and of the second product are subtracted, and 2^257 is added back when the difference comes out negative. The remainder is then shifted down by 11L when it is at least 8L, or by 3L otherwise. A short loop then adds or subtracts L, one step per cycle, until the value lies in [0, L).

Top module: `barrett_modl`

## Requirements
- R1: After a synchronous reset, `busy` and `done` are 0 and `result` is 0.
- R2: For any 512-bit operand accepted with `start`, the `result` presented with `done` equals the operand modulo L, with L = 2^252 + 27742317777372353535851937790883648493.
- R3: The boundary operands 0, 1, L−1, L, L+1, 8L, 2^256 and 2^512−1 each give their exact remainder modulo L.
- R4: `result` is always below L when `done` is 1.
- R5: `done` is high for exactly one cycle per accepted operand. `result` keeps its value until the next `done`.
- R6: A `start` pulse while `busy` is 1 is ignored. The running reduction completes with the remainder of the first operand, and no second reduction follows.
- R7: `busy` is 1 from the cycle after an accepted `start` until the cycle in which `done` is 1. `done` arrives no later than 560 cycles after `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request; operand sampled when idle |
| a_in | input | 512 | Operand to reduce |
| busy | output | 1 | Reduction in progress |
| done | output | 1 | One-cycle pulse: `result` is new |
| result | output | 253 | Operand modulo L |

## Verification
A fault in the quotient products or the 2^257 wrap leaves a remainder that is off by a multiple of L or by a power-of-two offset. That error appears in `result` on the very `done` pulse of that operand, so every operand is compared against a bit-serial remainder computed in the bench. A fault in the correction or final-loop control shows up either as a value at or above L, or as a changed latency. Latency is measured from `start` to `done` on every run. Sequencing faults, such as a start honoured while busy, appear as an extra `done` pulse or a wrong remainder within a few hundred cycles.

// File: rtl/barrett_modl_pkg.sv
package barrett_modl_pkg;
  localparam int IN_W   = 512;
  localparam int LW     = 253;            // width of L and of the result
  localparam int TRUNC  = 257;            // remainder kept mod 2^TRUNC
  localparam int SHIFT1 = 255;            // a is divided by 2^SHIFT1
  localparam int OPW    = IN_W - SHIFT1;  // 257-bit multiplier operands
  localparam int PW     = 2 * OPW;        // full product width
  localparam int SW     = TRUNC + 3;      // signed working width

  localparam logic [LW-1:0] MOD_L =
    253'h1000000000000000000000000000000014def9dea2f79cd65812631a5cf5d3ed;

  localparam logic signed [SW-1:0] L_S   = $signed({{(SW-LW){1'b0}}, MOD_L});
  localparam logic signed [SW-1:0] L3_S  = L_S * 3;
  localparam logic signed [SW-1:0] L8_S  = L_S * 8;
  localparam logic signed [SW-1:0] L11_S = L_S * 11;
  localparam logic signed [SW-1:0] WRAP_S = $signed({{(SW-TRUNC-1){1'b0}}, 1'b1, {TRUNC{1'b0}}});

  // floor(2^512 / (8L)) = floor(2^509 / L), by restoring division
  function automatic logic [OPW-1:0] calc_t();
    logic [LW+1:0] rem;
    logic [OPW-1:0] q;
    rem = '0;
    q   = '0;
    for (int i = IN_W - 3; i >= 0; i--) begin
      rem = {rem[LW:0], (i == IN_W - 3) ? 1'b1 : 1'b0};
      if (rem >= {1'b0, MOD_L}) begin
        rem = rem - {1'b0, MOD_L};
        if (i < OPW) q[i] = 1'b1;
      end
    end
    return q;
  endfunction

  localparam logic [OPW-1:0] T_CONST = calc_t();
  localparam logic [OPW-1:0] L8_OP   = {{(OPW-LW-3){1'b0}}, MOD_L, 3'b000};

  typedef enum logic [2:0] {ST_IDLE, ST_MUL1, ST_MUL2, ST_FIX, ST_FINAL} st_t;
endpackage

// File: rtl/barrett_serial_mul.sv
module barrett_serial_mul #(
  parameter int AW = 257,
  parameter int BW = 257,
  localparam int PWD = AW + BW,
  localparam int CW = $clog2(BW + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic [AW-1:0]  op_a,
  input  logic [BW-1:0]  op_b,
  output logic           fin,
  output logic [PWD-1:0] prod
);
  logic [PWD-1:0] mcand;
  logic [BW-1:0]  mplier;
  logic [CW-1:0]  cnt;
  logic           run;

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand  <= '0;
      mplier <= '0;
      cnt    <= '0;
      run    <= 1'b0;
      fin    <= 1'b0;
      prod   <= '0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        mcand  <= {{BW{1'b0}}, op_a};
        mplier <= op_b;
        cnt    <= '0;
        run    <= 1'b1;
        prod   <= '0;
      end else if (run) begin
        if (mplier[0]) prod <= prod + mcand;
        mcand  <= mcand << 1;
        mplier <= mplier >> 1;
        cnt    <= cnt + 1'b1;
        if (cnt == CW'(BW - 1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/barrett_fix.sv
module barrett_fix
  import barrett_modl_pkg::*;
(
  input  logic [TRUNC-1:0]       a_lo,
  input  logic [TRUNC-1:0]       q2_lo,
  output logic signed [SW-1:0]   r_out
);
  logic signed [SW-1:0] diff;
  logic signed [SW-1:0] wrapped;

  always_comb begin
    diff    = $signed({{(SW-TRUNC){1'b0}}, a_lo}) - $signed({{(SW-TRUNC){1'b0}}, q2_lo});
    wrapped = (diff < 0) ? diff + WRAP_S : diff;
    r_out   = (wrapped >= L8_S) ? wrapped - L11_S : wrapped - L3_S;
  end
endmodule

// File: rtl/barrett_step.sv
module barrett_step
  import barrett_modl_pkg::*;
(
  input  logic signed [SW-1:0] r_in,
  output logic signed [SW-1:0] r_next,
  output logic                 in_range
);
  always_comb begin
    in_range = (r_in >= 0) && (r_in < L_S);
    if (r_in < 0)          r_next = r_in + L_S;
    else if (r_in >= L_S)  r_next = r_in - L_S;
    else                   r_next = r_in;
  end
endmodule

// File: rtl/barrett_modl.sv
module barrett_modl
  import barrett_modl_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [IN_W-1:0] a_in,
  output logic            busy,
  output logic            done,
  output logic [LW-1:0]   result
);
  st_t                  state;
  logic [TRUNC-1:0]     a_lo;
  logic signed [SW-1:0] r_q;
  logic                 mul_go;
  logic [OPW-1:0]       mul_a;
  logic [OPW-1:0]       mul_b;
  logic                 mul_fin;
  logic [PW-1:0]        mul_p;
  logic signed [SW-1:0] fix_r;
  logic signed [SW-1:0] step_r;
  logic                 step_ok;

  always_comb begin
    mul_go = 1'b0;
    mul_a  = a_in[IN_W-1:SHIFT1];
    mul_b  = T_CONST;
    if (state == ST_IDLE && start) begin
      mul_go = 1'b1;
    end else if (state == ST_MUL1) begin
      mul_a  = mul_p[PW-1:TRUNC];
      mul_b  = L8_OP;
      mul_go = mul_fin;
    end
  end

  barrett_serial_mul #(.AW(OPW), .BW(OPW)) u_mul (
    .clk(clk), .rst(rst), .go(mul_go), .op_a(mul_a), .op_b(mul_b),
    .fin(mul_fin), .prod(mul_p)
  );

  barrett_fix u_fix (.a_lo(a_lo), .q2_lo(mul_p[TRUNC-1:0]), .r_out(fix_r));

  barrett_step u_step (.r_in(r_q), .r_next(step_r), .in_range(step_ok));

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      a_lo   <= '0;
      r_q    <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          a_lo  <= a_in[TRUNC-1:0];
          busy  <= 1'b1;
          state <= ST_MUL1;
        end
        ST_MUL1: if (mul_fin) state <= ST_MUL2;
        ST_MUL2: if (mul_fin) state <= ST_FIX;
        ST_FIX: begin
          r_q   <= fix_r;
          state <= ST_FINAL;
        end
        ST_FINAL: begin
          if (step_ok) begin
            result <= r_q[LW-1:0];
            done   <= 1'b1;
            busy   <= 1'b0;
            state  <= ST_IDLE;
          end else begin
            r_q <= step_r;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/barrett_modl_chk.sv
module barrett_modl_chk
  import barrett_modl_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [LW-1:0] result
);
  a_r4_result_below_l: assert property (@(posedge clk) disable iff (rst)
    done |-> (result < MOD_L));

  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r5_result_held: assert property (@(posedge clk) disable iff (rst)
    !done |=> ($stable(result) || done));

  a_r7_busy_after_start: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r6_done_needs_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy));
endmodule

bind barrett_modl barrett_modl_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .result(result)
);

// File: tb/barrett_modl_test.sv
module barrett_modl_test;
  localparam logic [252:0] LV =
    253'h1000000000000000000000000000000014def9dea2f79cd65812631a5cf5d3ed;
  localparam int MAX_LAT = 560;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [511:0] a_in = '0;
  logic         busy;
  logic         done;
  logic [252:0] result;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  barrett_modl uut (
    .clk(clk), .rst(rst), .start(start), .a_in(a_in),
    .busy(busy), .done(done), .result(result)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: run did not end (actual %0d cycles, expected < 150000)", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [252:0] ref_mod(input logic [511:0] v);
    logic [253:0] rem = '0;
    for (int i = 511; i >= 0; i--) begin
      rem = {rem[252:0], v[i]};
      if (rem >= {1'b0, LV}) rem = rem - {1'b0, LV};
    end
    return rem[252:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [511:0] act,
                       input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // R2/R3/R5/R7: one operand, full handshake
  task automatic run_case(input logic [511:0] v, input string req);
    int lat = 0;
    logic [252:0] exp = ref_mod(v);
    logic [252:0] got;
    @(negedge clk);
    a_in = v; start = 1'b1;
    @(negedge clk);
    start = 1'b0; a_in = '0;
    check(busy === 1'b1, "R7 busy after start", 512'(busy), 512'd1);
    while (done !== 1'b1 && lat < MAX_LAT + 20) begin
      @(negedge clk); lat++;
    end
    check(lat <= MAX_LAT, "R7 latency", 512'(lat), 512'(MAX_LAT));
    check(result === exp, req, 512'(result), 512'(exp));
    check(busy === 1'b0, "R7 busy low with done", 512'(busy), 512'd0);
    got = result;
    @(negedge clk);
    check(done === 1'b0, "R5 done one cycle", 512'(done), 512'd0);
    @(negedge clk);
    check(result === got, "R5 result held", 512'(result), 512'(got));
  endtask

  task automatic t_reset();
    check(busy === 1'b0 && done === 1'b0, "R1 reset flags", 512'({busy, done}), 512'd0);
    check(result === '0, "R1 reset result", 512'(result), 512'd0);
  endtask

  task automatic t_edges();
    run_case(512'd0,                  "R3 zero");
    run_case(512'd1,                  "R3 one");
    run_case(512'(LV) - 1,            "R3 L-1");
    run_case(512'(LV),                "R3 L");
    run_case(512'(LV) + 1,            "R3 L+1");
    run_case(512'(LV) << 3,           "R3 8L");
    run_case(512'd1 << 256,           "R3 2^256");
    run_case({512{1'b1}},             "R3 all ones");
    run_case((512'(LV) << 3) - 1,     "R3 8L-1");
  endtask

  task automatic t_random();
    for (int n = 0; n < 8; n++) begin
      logic [511:0] v;
      for (int w = 0; w < 16; w++) v[w*32 +: 32] = $urandom();
      if (n == 1) v[511:480] = 32'hffffffff;
      if (n == 2) v[511:300] = '0;
      run_case(v, "R2 random");
    end
  endtask

  task automatic t_start_ignored();
    logic [511:0] v1 = {16{32'h9e3779b9}};
    logic [511:0] v2 = 512'd12345;
    logic [252:0] exp = ref_mod(v1);
    int lat = 0;
    int pulses = 0;
    @(negedge clk);
    a_in = v1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    a_in = v2; start = 1'b1;
    @(negedge clk);
    start = 1'b0; a_in = '0;
    while (done !== 1'b1 && lat < MAX_LAT + 20) begin
      @(negedge clk); lat++;
    end
    check(result === exp, "R6 first operand kept", 512'(result), 512'(exp));
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (done === 1'b1) pulses++;
    end
    check(pulses == 0, "R6 no second run", 512'(pulses), 512'd0);
    check(busy === 1'b0, "R6 idle after", 512'(busy), 512'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_edges();
    t_random();
    t_start_ignored();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule